// File: doc/BRIEF.md
# Crypto Channel Job Sequencer

This block sits between four channels and one shared cryptographic execution unit. A channel that has decoded its descriptor header raises its request line. A software-set ranking picks the channel that is served next. The winning channel keeps its grant until its whole job is finished. During the job the block strobes the unit's mode setting. It then loads context, loads data, waits for the unit's done flag and stores the results. It repeats the load, compute and store triple for each chained service.

When the last store has been acknowledged, the block resets the unit if the channel uses it as a dynamically assigned resource. It then reports completion. Completion is reported either by a one-cycle interrupt pulse or by a header writeback command on the memory port. It can be reported for every descriptor or only for the descriptor that closes a chain. Every memory access is a request/acknowledge handshake. A wait that runs past a programmable limit aborts the job and raises an error flag.

Top module: `chan_job_seq`

## Requirements
- R1: `grant_o` is one-hot or zero. It stays on the same channel from the first cycle of a job to its last. A request from a higher-ranked channel that arrives during a job does not pre-empt that job. The next winner is chosen only after the current job has completed.
- R2: `prio_i` holds one 2-bit channel index for each rank. The field at bits [2r+1:2r] names the channel of rank r, and rank 0 is the highest. When the fields form a permutation, the highest-ranked requesting channel is granted.
- R3: When any channel index is missing from `prio_i` or appears more than once, arbitration falls back to the fixed order channel 0, 1, 2, 3, with channel 0 first.
- R4: A job starts with `eu_mode_o` high for exactly one cycle. Then come a context load (`mem_cmd_o` = 0), a data load (`mem_cmd_o` = 1), a wait for `eu_done_i`, and a result store (`mem_cmd_o` = 2).
- R5: A job whose service count is N runs N context/data/store triples, and the service count is read at grant time. After every store except the last, the sequence returns to the context load. A count of 0 is treated as 1.
- R6: For a dynamically assigned unit, `eu_rst_o` pulses for one cycle after the last store. A statically assigned unit gets no reset from a job. `eu_rst_cmd_i` drives `eu_rst_o` in the same cycle at any time.
- R7: With `notify_irq_i` = 1, completion is a one-cycle `irq_o` pulse. With `notify_irq_i` = 0, completion is a header writeback command (`mem_cmd_o` = 3).
- R8: With `notify_chain_i` = 0, every job reports completion. With `notify_chain_i` = 1, only a job whose chain-end flag is set reports completion.
- R9: `eu_done_i` has an effect only while the sequencer waits for the unit. A done flag seen in any other phase neither skips nor shortens the wait.
- R10: The wait may last at most `wait_limit_i` cycles, where the limit is at least 1, and a done flag seen in the last allowed cycle is accepted. If no done flag arrives in that time, `err_o` is set, no store is issued, the grant drops and the block returns to idle. `err_o` stays set until the next grant.
- R11: `mem_req_o` stays high with `mem_cmd_o` unchanged until `mem_ack_i` is seen. The sequence does not advance while the acknowledge is missing.
- R12: During reset there is no grant, no memory request, no strobe and no interrupt, and `err_o` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| req_i | input | 4 | Per-channel service request |
| prio_i | input | 8 | Rank table, 2-bit channel index per rank, rank 0 in bits [1:0] |
| chan_nsvc_i | input | 12 | Per-channel service count, 3 bits each, channel c at [3c+2:3c] |
| chan_dyn_i | input | 4 | Per-channel flag: unit is dynamically assigned |
| chan_last_i | input | 4 | Per-channel flag: descriptor closes a chain |
| notify_irq_i | input | 1 | 1 = report completion by interrupt, 0 = by header writeback |
| notify_chain_i | input | 1 | 1 = report completion only at the end of a chain |
| wait_limit_i | input | 16 | Maximum number of cycles spent waiting for the unit |
| eu_rst_cmd_i | input | 1 | Explicit unit reset command |
| eu_done_i | input | 1 | Unit has finished its computation |
| mem_ack_i | input | 1 | Memory command accepted |
| grant_o | output | 4 | One-hot grant to the channel being served |
| eu_mode_o | output | 1 | One-cycle strobe that sets the unit's mode |
| mem_req_o | output | 1 | Memory command valid |
| mem_cmd_o | output | 2 | 0 context load, 1 data load, 2 result store, 3 header writeback |
| eu_rst_o | output | 1 | Unit reset strobe |
| irq_o | output | 1 | Completion interrupt pulse |
| err_o | output | 1 | Wait timeout flag |

## Verification
The embedded properties check on every cycle that the grant is one-hot, that it is held for the whole job and that it was requested. They also check that a memory command is held stable until acknowledged, that a mode strobe is always followed by a context load, and that a job-driven unit reset follows an acknowledged store. They check that an interrupt never coincides with a memory request and that a timeout leaves no grant behind. The directed scenarios cover the rest: the service order under several rank tables and an invalid one, chained services, both notification forms and both notification scopes, done flags injected outside the wait, and the exact cycle on which the wait limit accepts or rejects a done flag.

// File: rtl/cjs_pkg.sv
package cjs_pkg;

  // memory command codes seen on mem_cmd_o
  localparam int CMDW = 2;
  localparam logic [CMDW-1:0] CMD_CTX   = 2'd0;
  localparam logic [CMDW-1:0] CMD_DATA  = 2'd1;
  localparam logic [CMDW-1:0] CMD_STORE = 2'd2;
  localparam logic [CMDW-1:0] CMD_HDR   = 2'd3;

  typedef enum logic [2:0] {
    S_IDLE,
    S_MODE,
    S_CTX,
    S_DATA,
    S_WAIT,
    S_UNLD,
    S_RST,
    S_NTFY
  } seq_state_t;

endpackage

// File: rtl/cjs_rst_sync.sv
module cjs_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic srst_n
);

  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= {sync_q[0], 1'b1};
  end

  assign srst_n = sync_q[1];

endmodule

// File: rtl/cjs_arbiter.sv
module cjs_arbiter #(
  parameter int NCH  = 4,
  parameter int IDXW = $clog2(NCH)
) (
  input  logic [NCH-1:0]      req,
  input  logic [NCH*IDXW-1:0] prio,
  output logic [NCH-1:0]      win,
  output logic                any
);

  logic [NCH-1:0]  match [NCH];
  logic [NCH-1:0]  once;
  logic            perm_ok;
  logic [IDXW-1:0] ord [NCH];

  // each channel index must appear in exactly one rank field
  for (genvar c = 0; c < NCH; c++) begin : g_chan
    for (genvar r = 0; r < NCH; r++) begin : g_rank
      assign match[c][r] = (prio[r*IDXW +: IDXW] == IDXW'(c));
    end
    assign once[c] = $onehot(match[c]);
  end

  assign perm_ok = &once;

  for (genvar r = 0; r < NCH; r++) begin : g_ord
    assign ord[r] = perm_ok ? prio[r*IDXW +: IDXW] : IDXW'(r);
  end

  // lowest rank number that requests wins, so scan from the bottom up
  always_comb begin
    win = '0;
    any = 1'b0;
    for (int r = NCH - 1; r >= 0; r--) begin
      if (req[ord[r]]) begin
        win          = '0;
        win[ord[r]]  = 1'b1;
        any          = 1'b1;
      end
    end
  end

endmodule

// File: rtl/cjs_wait_timer.sv
module cjs_wait_timer #(
  parameter int TW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          run,
  input  logic [TW-1:0] limit,
  output logic          expired
);

  logic [TW-1:0] cnt_q, cnt_d;
  logic          cnt_en;
  logic [TW-1:0] lim_m1;

  assign lim_m1  = limit - TW'(1);
  assign cnt_en  = run | (cnt_q != '0);
  assign cnt_d   = run ? cnt_q + TW'(1) : '0;
  assign expired = run && (cnt_q == lim_m1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

endmodule

// File: rtl/cjs_seq_fsm.sv
module cjs_seq_fsm
  import cjs_pkg::*;
#(
  parameter int NCH  = 4,
  parameter int SVCW = 3
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [NCH-1:0]      arb_win,
  input  logic                arb_any,
  input  logic [NCH*SVCW-1:0] chan_nsvc,
  input  logic [NCH-1:0]      chan_dyn,
  input  logic [NCH-1:0]      chan_last,
  input  logic                notify_irq,
  input  logic                notify_chain,
  input  logic                eu_rst_cmd,
  input  logic                eu_done,
  input  logic                mem_ack,
  input  logic                tmo,
  output logic [NCH-1:0]      grant,
  output logic                eu_mode,
  output logic                mem_req,
  output logic [CMDW-1:0]     mem_cmd,
  output logic                eu_rst,
  output logic                irq,
  output logic                err,
  output logic                in_wait
);

  seq_state_t      state_q, state_d;
  logic [NCH-1:0]  grant_q;
  logic [SVCW-1:0] rem_q, rem_d;
  logic            dyn_q, last_q, err_q, err_d;
  logic [SVCW-1:0] sel_nsvc;
  logic            sel_dyn, sel_last;
  logic            cap, rem_dec, err_en;
  logic            notify_now, wb_req;

  // pick the attributes of the channel about to be granted
  always_comb begin
    sel_nsvc = '0;
    sel_dyn  = 1'b0;
    sel_last = 1'b0;
    for (int c = 0; c < NCH; c++) begin
      if (arb_win[c]) begin
        sel_nsvc = sel_nsvc | chan_nsvc[c*SVCW +: SVCW];
        sel_dyn  = sel_dyn  | chan_dyn[c];
        sel_last = sel_last | chan_last[c];
      end
    end
  end

  assign cap        = (state_q == S_IDLE) && arb_any;
  assign notify_now = !notify_chain || last_q;
  assign wb_req     = (state_q == S_NTFY) && notify_now && !notify_irq;

  // next-state process
  always_comb begin
    state_d = state_q;
    rem_d   = rem_q;
    err_d   = err_q;
    rem_dec = 1'b0;
    err_en  = 1'b0;
    unique case (state_q)
      S_IDLE: begin
        if (arb_any) begin
          state_d = S_MODE;
          rem_d   = (sel_nsvc == '0) ? SVCW'(1) : sel_nsvc;
          err_d   = 1'b0;
          err_en  = 1'b1;
        end
      end
      S_MODE: state_d = S_CTX;
      S_CTX:  if (mem_ack) state_d = S_DATA;
      S_DATA: if (mem_ack) state_d = S_WAIT;
      S_WAIT: begin
        if (eu_done) begin
          state_d = S_UNLD;
        end else if (tmo) begin
          state_d = S_IDLE;
          err_d   = 1'b1;
          err_en  = 1'b1;
        end
      end
      S_UNLD: begin
        if (mem_ack) begin
          if (rem_q > SVCW'(1)) begin
            state_d = S_CTX;
            rem_d   = rem_q - SVCW'(1);
            rem_dec = 1'b1;
          end else if (dyn_q) begin
            state_d = S_RST;
          end else begin
            state_d = S_NTFY;
          end
        end
      end
      S_RST:  state_d = S_NTFY;
      S_NTFY: if (!wb_req || mem_ack) state_d = S_IDLE;
      default: state_d = S_IDLE;
    endcase
  end

  // register process
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= S_IDLE;
      grant_q <= '0;
      rem_q   <= '0;
      dyn_q   <= 1'b0;
      last_q  <= 1'b0;
      err_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      if (cap) begin
        grant_q <= arb_win;
        dyn_q   <= sel_dyn;
        last_q  <= sel_last;
      end
      if (cap || rem_dec) rem_q <= rem_d;
      if (err_en)         err_q <= err_d;
    end
  end

  // outputs decoded from the registered state
  always_comb begin
    mem_req = 1'b0;
    mem_cmd = CMD_CTX;
    unique case (state_q)
      S_CTX:  begin mem_req = 1'b1; mem_cmd = CMD_CTX;   end
      S_DATA: begin mem_req = 1'b1; mem_cmd = CMD_DATA;  end
      S_UNLD: begin mem_req = 1'b1; mem_cmd = CMD_STORE; end
      S_NTFY: begin mem_req = wb_req; mem_cmd = CMD_HDR; end
      default: ;
    endcase
  end

  assign grant   = (state_q != S_IDLE) ? grant_q : '0;
  assign eu_mode = (state_q == S_MODE);
  assign eu_rst  = (state_q == S_RST) | eu_rst_cmd;
  assign irq     = (state_q == S_NTFY) && notify_now && notify_irq;
  assign err     = err_q;
  assign in_wait = (state_q == S_WAIT);

  // R4: the mode strobe is followed directly by the context load
  p_mode_then_ctx_r4: assert property (@(posedge clk) disable iff (!rst_n)
    eu_mode |=> (mem_req && mem_cmd == CMD_CTX));

  // R4: a new store request only ever follows an accepted done flag
  p_store_after_done_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && mem_cmd == CMD_STORE && !$past(mem_req && mem_cmd == CMD_STORE))
      |-> $past(eu_done));

  // R11: an unacknowledged command is held with the same code
  p_req_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_ack) |=> (mem_req && $stable(mem_cmd)));

  // R7: interrupt and header writeback never happen together
  p_irq_no_req_r7: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> !mem_req);

endmodule

// File: rtl/chan_job_seq.sv
module chan_job_seq
  import cjs_pkg::*;
#(
  parameter int NCH  = 4,
  parameter int SVCW = 3,
  parameter int TW   = 16,
  localparam int IDXW = $clog2(NCH)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [NCH-1:0]      req_i,
  input  logic [NCH*IDXW-1:0] prio_i,
  input  logic [NCH*SVCW-1:0] chan_nsvc_i,
  input  logic [NCH-1:0]      chan_dyn_i,
  input  logic [NCH-1:0]      chan_last_i,
  input  logic                notify_irq_i,
  input  logic                notify_chain_i,
  input  logic [TW-1:0]       wait_limit_i,
  input  logic                eu_rst_cmd_i,
  input  logic                eu_done_i,
  input  logic                mem_ack_i,
  output logic [NCH-1:0]      grant_o,
  output logic                eu_mode_o,
  output logic                mem_req_o,
  output logic [CMDW-1:0]     mem_cmd_o,
  output logic                eu_rst_o,
  output logic                irq_o,
  output logic                err_o
);

  logic           srst_n;
  logic [NCH-1:0] arb_win;
  logic           arb_any;
  logic           in_wait;
  logic           tmo;

  cjs_rst_sync u_rst_sync (
    .clk    (clk),
    .rst_n  (rst_n),
    .srst_n (srst_n)
  );

  cjs_arbiter #(.NCH(NCH), .IDXW(IDXW)) u_arb (
    .req  (req_i),
    .prio (prio_i),
    .win  (arb_win),
    .any  (arb_any)
  );

  cjs_wait_timer #(.TW(TW)) u_timer (
    .clk     (clk),
    .rst_n   (srst_n),
    .run     (in_wait),
    .limit   (wait_limit_i),
    .expired (tmo)
  );

  cjs_seq_fsm #(.NCH(NCH), .SVCW(SVCW)) u_fsm (
    .clk          (clk),
    .rst_n        (srst_n),
    .arb_win      (arb_win),
    .arb_any      (arb_any),
    .chan_nsvc    (chan_nsvc_i),
    .chan_dyn     (chan_dyn_i),
    .chan_last    (chan_last_i),
    .notify_irq   (notify_irq_i),
    .notify_chain (notify_chain_i),
    .eu_rst_cmd   (eu_rst_cmd_i),
    .eu_done      (eu_done_i),
    .mem_ack      (mem_ack_i),
    .tmo          (tmo),
    .grant        (grant_o),
    .eu_mode      (eu_mode_o),
    .mem_req      (mem_req_o),
    .mem_cmd      (mem_cmd_o),
    .eu_rst       (eu_rst_o),
    .irq          (irq_o),
    .err          (err_o),
    .in_wait      (in_wait)
  );

  // R1: at most one channel holds the grant
  p_grant_onehot_r1: assert property (@(posedge clk) disable iff (!srst_n)
    $onehot0(grant_o));

  // R1: a grant never moves to another channel without first dropping
  p_grant_stable_r1: assert property (@(posedge clk) disable iff (!srst_n)
    (grant_o != '0) |=> ((grant_o == $past(grant_o)) || (grant_o == '0)));

  // R2: a fresh grant goes to a channel that was requesting
  p_grant_from_req_r2: assert property (@(posedge clk) disable iff (!srst_n)
    $rose(|grant_o) |-> (($past(req_i) & grant_o) != '0));

  // R6: a job-driven unit reset follows an accepted store
  p_rst_src_r6: assert property (@(posedge clk) disable iff (!srst_n)
    (eu_rst_o && !eu_rst_cmd_i) |->
      $past(mem_req_o && mem_cmd_o == CMD_STORE && mem_ack_i));

  // R10: the error flag rises only as the job is abandoned
  p_err_idle_r10: assert property (@(posedge clk) disable iff (!srst_n)
    $rose(err_o) |-> (grant_o == '0));

endmodule

// File: tb/chan_job_seq_tb.sv
module chan_job_seq_tb;

  localparam int NCH  = 4;
  localparam int SVCW = 3;
  localparam int TW   = 16;

  logic               clk;
  logic               rst_n;
  logic [NCH-1:0]     req_i;
  logic [7:0]         prio_i;
  logic [NCH*SVCW-1:0] chan_nsvc_i;
  logic [NCH-1:0]     chan_dyn_i;
  logic [NCH-1:0]     chan_last_i;
  logic               notify_irq_i;
  logic               notify_chain_i;
  logic [TW-1:0]      wait_limit_i;
  logic               eu_rst_cmd_i;
  logic               eu_done_i;
  logic               mem_ack_i;
  logic [NCH-1:0]     grant_o;
  logic               eu_mode_o;
  logic               mem_req_o;
  logic [1:0]         mem_cmd_o;
  logic               eu_rst_o;
  logic               irq_o;
  logic               err_o;

  int n_chk  = 0;
  int n_fail = 0;

  // bench-side models of memory and unit
  string      log_s;
  string      gseq;
  int         ack_gap;
  int         gap_cnt;
  int         done_delay;
  int         done_cnt;
  bit         spur_mode;
  bit         data_seen;
  int         stall_n;
  int         glitch_n;
  bit         have_pend;
  logic [1:0] pend_cmd;
  logic [NCH-1:0] prev_g;

  chan_job_seq #(.NCH(NCH), .SVCW(SVCW), .TW(TW)) u_dut (
    .clk            (clk),
    .rst_n          (rst_n),
    .req_i          (req_i),
    .prio_i         (prio_i),
    .chan_nsvc_i    (chan_nsvc_i),
    .chan_dyn_i     (chan_dyn_i),
    .chan_last_i    (chan_last_i),
    .notify_irq_i   (notify_irq_i),
    .notify_chain_i (notify_chain_i),
    .wait_limit_i   (wait_limit_i),
    .eu_rst_cmd_i   (eu_rst_cmd_i),
    .eu_done_i      (eu_done_i),
    .mem_ack_i      (mem_ack_i),
    .grant_o        (grant_o),
    .eu_mode_o      (eu_mode_o),
    .mem_req_o      (mem_req_o),
    .mem_cmd_o      (mem_cmd_o),
    .eu_rst_o       (eu_rst_o),
    .irq_o          (irq_o),
    .err_o          (err_o)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  function automatic string cmd_char(logic [1:0] c);
    case (c)
      2'd0: return "C";
      2'd1: return "D";
      2'd2: return "U";
      default: return "H";
    endcase
  endfunction

  function automatic string idx_char(logic [NCH-1:0] g);
    string s = "?";
    for (int c = 0; c < NCH; c++) if (g[c]) s.itoa(c);
    return s;
  endfunction

  task automatic chk_s(string tag, string what, string act, string exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual=%s expected=%s", tag, what, act, exp);
    end
  endtask

  task automatic chk_i(string tag, string what, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  // one cycle: observe outputs at the falling edge and drive the models
  task automatic step();
    @(negedge clk);
    if (spur_mode && !data_seen) eu_done_i = 1'b1;
    else if (done_cnt == 0)      eu_done_i = 1'b1;
    else                         eu_done_i = 1'b0;
    if (done_cnt >= 0) done_cnt--;
    if (eu_mode_o) log_s = {log_s, "M"};
    if (eu_rst_o)  log_s = {log_s, "R"};
    if (irq_o)     log_s = {log_s, "I"};
    if (mem_ack_i) begin
      mem_ack_i = 1'b0;
    end else if (mem_req_o) begin
      if (have_pend && mem_cmd_o != pend_cmd) glitch_n++;
      pend_cmd  = mem_cmd_o;
      have_pend = 1'b1;
      if (gap_cnt > 0) begin
        gap_cnt--;
        stall_n++;
      end else begin
        log_s     = {log_s, cmd_char(mem_cmd_o)};
        mem_ack_i = 1'b1;
        gap_cnt   = ack_gap;
        have_pend = 1'b0;
        if (mem_cmd_o == 2'd1) begin
          data_seen = 1'b1;
          if (done_delay >= 0) done_cnt = done_delay;
        end
      end
    end
    if (grant_o != '0 && prev_g == '0) gseq = {gseq, idx_char(grant_o)};
    req_i  = req_i & ~grant_o;
    prev_g = grant_o;
  endtask

  task automatic run(int n);
    for (int i = 0; i < n; i++) step();
  endtask

  task automatic prep(int gap, int dly);
    log_s      = "";
    gseq       = "";
    ack_gap    = gap;
    gap_cnt    = gap;
    done_delay = dly;
    done_cnt   = -1;
    spur_mode  = 1'b0;
    data_seen  = 1'b0;
    stall_n    = 0;
    glitch_n   = 0;
    have_pend  = 1'b0;
  endtask

  task automatic set_chan(int nsvc, bit dyn, bit last);
    for (int c = 0; c < NCH; c++) begin
      chan_nsvc_i[c*SVCW +: SVCW] = SVCW'(nsvc);
      chan_dyn_i[c]  = dyn;
      chan_last_i[c] = last;
    end
  endtask

  task automatic t_reset();
    rst_n = 1'b0;
    run(3);
    chk_i("R12", "grant in reset", int'(grant_o), 0);
    chk_i("R12", "strobes in reset",
          int'({mem_req_o, eu_mode_o, irq_o, err_o}), 0);
    rst_n = 1'b1;
    run(4);
    chk_i("R12", "grant after reset", int'(grant_o), 0);
  endtask

  task automatic t_basic_dyn_irq();
    prep(0, 2);
    set_chan(1, 1'b1, 1'b1);
    notify_irq_i = 1'b1; notify_chain_i = 1'b0;
    req_i = 4'b0010;
    run(40);
    chk_s("R4", "single dynamic job order", log_s, "MCDURI");
    chk_s("R6", "dynamic job grant", gseq, "1");
  endtask

  task automatic t_chain_static_wb();
    prep(0, 1);
    set_chan(3, 1'b0, 1'b1);
    notify_irq_i = 1'b0; notify_chain_i = 1'b0;
    req_i = 4'b0001;
    run(60);
    chk_s("R5", "three chained services, static, writeback", log_s, "MCDUCDUCDUH");
    prep(0, 0);
    set_chan(0, 1'b0, 1'b1);
    req_i = 4'b0100;
    run(30);
    chk_s("R7", "count 0 runs once, writeback", log_s, "MCDUH");
  endtask

  task automatic t_chain_scope();
    prep(0, 0);
    set_chan(1, 1'b0, 1'b0);
    notify_irq_i = 1'b1; notify_chain_i = 1'b1;
    req_i = 4'b1000;
    run(30);
    chk_s("R8", "mid-chain job stays silent", log_s, "MCDU");
    prep(0, 0);
    set_chan(1, 1'b0, 1'b1);
    req_i = 4'b1000;
    run(30);
    chk_s("R8", "chain-end job interrupts", log_s, "MCDUI");
  endtask

  task automatic t_priority();
    prep(0, 0);
    set_chan(1, 1'b0, 1'b1);
    notify_irq_i = 1'b1; notify_chain_i = 1'b0;
    prio_i = {2'd1, 2'd3, 2'd0, 2'd2};
    req_i = 4'b1111;
    run(100);
    chk_s("R2", "rank table 2,0,3,1", gseq, "2031");
    chk_s("R2", "four complete jobs", log_s, "MCDUIMCDUIMCDUIMCDUI");
    prep(0, 0);
    prio_i = {2'd2, 2'd1, 2'd0, 2'd0};
    req_i = 4'b1111;
    run(100);
    chk_s("R3", "duplicate index falls back", gseq, "0123");
    prio_i = {2'd3, 2'd2, 2'd1, 2'd0};
  endtask

  task automatic t_no_preempt();
    prep(0, 3);
    set_chan(1, 1'b0, 1'b1);
    req_i = 4'b1000;
    run(3);
    req_i[0] = 1'b1;
    run(50);
    chk_s("R1", "grant order without pre-emption", gseq, "30");
    chk_s("R1", "first job completes before second", log_s, "MCDUIMCDUI");
  endtask

  task automatic t_spurious_done();
    wait_limit_i = 16'd4;
    prep(3, -1);
    spur_mode = 1'b1;
    set_chan(1, 1'b0, 1'b1);
    req_i = 4'b0100;
    run(40);
    chk_s("R9", "done outside wait ignored", log_s, "MCD");
    chk_i("R9", "timeout still raised", int'(err_o), 1);
  endtask

  task automatic t_timeout();
    wait_limit_i = 16'd5;
    prep(0, 4);
    set_chan(1, 1'b0, 1'b1);
    req_i = 4'b0001;
    run(30);
    chk_s("R10", "done on last allowed cycle", log_s, "MCDUI");
    chk_i("R10", "no error at limit", int'(err_o), 0);
    prep(0, 5);
    req_i = 4'b0001;
    run(30);
    chk_s("R10", "done one cycle late", log_s, "MCD");
    chk_i("R10", "error raised", int'(err_o), 1);
    chk_i("R10", "grant dropped", int'(grant_o), 0);
    prep(0, 0);
    req_i = 4'b0010;
    run(30);
    chk_i("R10", "error cleared by next grant", int'(err_o), 0);
    wait_limit_i = 16'd100;
  endtask

  task automatic t_stall();
    prep(4, 1);
    set_chan(2, 1'b1, 1'b1);
    notify_irq_i = 1'b0;
    req_i = 4'b0100;
    run(120);
    chk_s("R11", "slow acknowledge keeps order", log_s, "MCDUCDURH");
    chk_i("R11", "command changed while waiting", glitch_n, 0);
    chk_i("R11", "stall cycles seen", int'(stall_n > 0), 1);
  endtask

  task automatic t_rst_cmd();
    prep(0, 0);
    run(2);
    eu_rst_cmd_i = 1'b1;
    #1;
    chk_i("R6", "explicit reset while idle", int'(eu_rst_o), 1);
    step();
    eu_rst_cmd_i = 1'b0;
    #1;
    chk_i("R6", "reset released", int'(eu_rst_o), 0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: run did not finish");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    rst_n          = 1'b0;
    req_i          = '0;
    prio_i         = {2'd3, 2'd2, 2'd1, 2'd0};
    chan_nsvc_i    = '0;
    chan_dyn_i     = '0;
    chan_last_i    = '0;
    notify_irq_i   = 1'b1;
    notify_chain_i = 1'b0;
    wait_limit_i   = 16'd100;
    eu_rst_cmd_i   = 1'b0;
    eu_done_i      = 1'b0;
    mem_ack_i      = 1'b0;
    prev_g         = '0;
    prep(0, 0);
    t_reset();
    t_basic_dyn_irq();
    t_chain_static_wb();
    t_chain_scope();
    t_priority();
    t_no_preempt();
    t_spurious_done();
    t_timeout();
    t_stall();
    t_rst_cmd();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule